// File: doc/BRIEF.md
# Radian-Output Phase Accumulator

This block is the phase front end of a quadrature sine/cosine synthesizer whose amplitude stage computes values arithmetically rather than reading a table. Every clock a 32-bit tuning word is added to a free-running phase register. One wrap of that register is one output period. The three top phase bits select one of eight octants of the unit circle and leave the block unchanged. The bits below them are mirrored in every other octant, so the phase rises and then falls like a triangle. The mirrored value is then scaled by a fixed pi/4 coefficient, so it leaves as an angle in radians between 0 and pi/4.

A new tuning word is captured on `tune_load` and used from the following clock. Loading a word never clears the phase. A synchronous active-low reset clears the phase, the stored tuning word and the pipeline. `angle_valid` marks the cycles from which the outputs come from accumulated phase.

Top module: `radian_phase_gen`

## Requirements
- R1: With `rst_n` low at a clock edge, `angle_valid`, `angle_rad` and `octant` are 0 after that edge and the stored tuning word becomes 0. After release, `angle_valid` rises after the second edge with `rst_n` high and then stays high until the next reset.
- R2: The 32-bit phase register starts at 0 after reset and adds the stored tuning word on every clock, modulo 2^32. A word of 0 holds the phase, and a word of 0xFFFFFFFF steps it down by one.
- R3: A word presented with `tune_load` high is stored at that edge and is first added at the next edge. Without `tune_load` the stored word is kept.
- R4: `octant` equals bits 31:29 of the phase register as it was two edges before. This is the same phase sample that `angle_rad` is computed from.
- R5: The folded remainder is phase bits 28:7 (22 bits). It is bitwise complemented when phase bit 29 is 1, and passed through unchanged when bit 29 is 0.
- R6: `angle_rad` = floor(folded * 205887 / 2^22), where 205887 is pi/4 scaled by 2^18. The result is therefore always below 205887.
- R7: Loading a new tuning word does not reset or jump the phase. Accumulation continues from the current phase value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_load | input | 1 | Store `tune_word` at this edge |
| tune_word | input | 32 | Frequency tuning word |
| angle_rad | output | 18 | Folded angle, radians scaled by 2^18, range [0, pi/4) |
| octant | output | 3 | Octant select, top three phase bits, aligned with `angle_rad` |
| angle_valid | output | 1 | Outputs derived from post-reset phase |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any check starts. They also assume that `tune_load` and `tune_word` are stable around the rising edge, so the stored word can only change in a cycle after a load. The stimulus drives every input on the falling edge and holds reset for several cycles. It mixes random tuning words and random load timing with directed words: zero, one octant per step, and all ones. It also reasserts reset part-way through the run.

// File: rtl/rpg_pkg.sv
// Package rpg_pkg
// Shared widths and the fixed pi/4 coefficient for the radian phase generator.
// Assumes an unsigned binary fraction of COEF_W bits for the coefficient.
package rpg_pkg;
    localparam int unsigned TUNE_W = 32;   // tuning word and phase register width
    localparam int unsigned OCT_W  = 3;    // octant select bits taken from the top
    localparam int unsigned FOLD_W = 22;   // remainder bits fed to the multiplier
    localparam int unsigned COEF_W = 18;   // coefficient width
    localparam int unsigned RAD_W  = 18;   // radian output width

    // pi/4 as an unsigned fraction of w bits, truncated
    function automatic longint unsigned pi4_coef(input int unsigned w);
        return longint'($rtoi(0.7853981633974483 * (2.0 ** w)));
    endfunction
endpackage

// File: rtl/rpg_accum.sv
// Module rpg_accum
// Holds the tuning word and the phase register. The phase adds the stored
// word every clock. A load replaces the word for use from the next clock.
// Assumes: synchronous active-low reset, inputs stable around the edge.
module rpg_accum #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] phase
);
    logic [W-1:0] word_q;
    logic [W-1:0] phase_q;
    logic         armed;

    // tuning word register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= word_in;
    end

    // phase register: wraps modulo 2^W
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + word_q;
    end

    // marks that the previous cycle was out of reset, for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign phase = phase_q;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> phase_q == $past(phase_q) + $past(word_q)); // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(load)) |-> $stable(word_q)); // R3
endmodule

// File: rtl/rpg_fold.sv
// Module rpg_fold
// First pipeline stage and multiplier input register. It splits the phase
// into octant bits and a remainder, and mirrors the remainder (bitwise
// complement) in odd octants. Carries a valid bit set once out of reset.
// Assumes: W >= OCT_W + FW.
module rpg_fold #(
    parameter int unsigned W     = 32,
    parameter int unsigned OCT_W = 3,
    parameter int unsigned FW    = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     phase,
    output logic [OCT_W-1:0] oct_q,
    output logic [FW-1:0]    fold_q,
    output logic             vld_q
);
    localparam int unsigned REM_HI = W - OCT_W - 1;
    localparam int unsigned REM_LO = W - OCT_W - FW;
    localparam int unsigned MIRROR = W - OCT_W;   // lowest octant bit

    logic [FW-1:0]    rem;
    logic [FW-1:0]    fold_d;
    logic [OCT_W-1:0] oct_d;

    // pick octant and remainder fields, mirror on odd octants
    always_comb begin
        oct_d  = phase[W-1 -: OCT_W];
        rem    = phase[REM_HI:REM_LO];
        fold_d = phase[MIRROR] ? ~rem : rem;
    end

    // multiplier input register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_q  <= '0;
            fold_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            oct_q  <= oct_d;
            fold_q <= fold_d;
            vld_q  <= 1'b1;
        end
    end

    AST_OCT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> oct_q == $past(phase[W-1 -: OCT_W])); // R4
    AST_FOLD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !oct_q[0]) |-> fold_q == $past(phase[REM_HI:REM_LO])); // R5
endmodule

// File: rtl/rpg_scale.sv
// Module rpg_scale
// Fixed-coefficient multiplier with registered output, plus STAGES-1
// extra output stages. A side tag (octant and valid) travels through the
// same number of registers, so it stays aligned with the product.
// Assumes: STAGES >= 1, COEF < 2^CW.
module rpg_scale #(
    parameter int unsigned AW     = 22,
    parameter int unsigned CW     = 18,
    parameter int unsigned OW     = 18,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned STAGES = 1,
    parameter logic [CW-1:0] COEF = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    a_in,
    input  logic [TAG_W-1:0] tag_in,
    output logic [OW-1:0]    prod_top,
    output logic [TAG_W-1:0] tag_out
);
    localparam int unsigned PW = AW + CW;

    logic [PW-1:0]    prod_d;
    logic [OW-1:0]    pipe_p [STAGES];
    logic [TAG_W-1:0] pipe_t [STAGES];

    // multiply by the constant and keep the top OW bits
    always_comb prod_d = PW'(a_in) * PW'(COEF);

    // first output register straight after the multiplier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_p[0] <= '0;
            pipe_t[0] <= '0;
        end else begin
            pipe_p[0] <= prod_d[PW-1 -: OW];
            pipe_t[0] <= tag_in;
        end
    end

    // optional extra retiming stages, tag delayed alongside
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_p[s] <= '0;
                pipe_t[s] <= '0;
            end else begin
                pipe_p[s] <= pipe_p[s-1];
                pipe_t[s] <= pipe_t[s-1];
            end
        end
    end

    assign prod_top = pipe_p[STAGES-1];
    assign tag_out  = pipe_t[STAGES-1];

    AST_ANGLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_p[0] < COEF); // R6
endmodule

// File: rtl/radian_phase_gen.sv
// Module radian_phase_gen
// Top level: phase accumulator -> fold stage (multiplier input register)
// -> pi/4 scaling (multiplier output register). The octant bits and the
// valid flag travel with the angle. Latency from phase register to
// outputs is 1 + MUL_STAGES edges.
// Assumes: synchronous active-low reset held for at least one edge.
module radian_phase_gen
    import rpg_pkg::*;
#(
    parameter int unsigned MUL_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tune_load,
    input  logic [TUNE_W-1:0] tune_word,
    output logic [RAD_W-1:0]  angle_rad,
    output logic [OCT_W-1:0]  octant,
    output logic              angle_valid
);
    localparam logic [COEF_W-1:0] PI4 = COEF_W'(pi4_coef(COEF_W));
    localparam int unsigned TAG_W = OCT_W + 1;

    logic [TUNE_W-1:0] phase;
    logic [OCT_W-1:0]  oct1;
    logic [FOLD_W-1:0] fold1;
    logic              vld1;
    logic [TAG_W-1:0]  tag_o;

    rpg_accum #(.W(TUNE_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tune_load),
        .word_in (tune_word),
        .phase   (phase)
    );

    rpg_fold #(.W(TUNE_W), .OCT_W(OCT_W), .FW(FOLD_W)) u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .oct_q  (oct1),
        .fold_q (fold1),
        .vld_q  (vld1)
    );

    rpg_scale #(
        .AW(FOLD_W), .CW(COEF_W), .OW(RAD_W), .TAG_W(TAG_W),
        .STAGES(MUL_STAGES), .COEF(PI4)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (fold1),
        .tag_in   ({vld1, oct1}),
        .prod_top (angle_rad),
        .tag_out  (tag_o)
    );

    assign octant      = tag_o[OCT_W-1:0];
    assign angle_valid = tag_o[OCT_W];

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        angle_valid |=> angle_valid); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!angle_valid && angle_rad == '0 && octant == '0)); // R1
endmodule

// File: tb/radian_phase_gen_test.sv
module radian_phase_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tune_load = 1'b0;
    logic [31:0] tune_word = '0;
    logic [17:0] angle_rad;
    logic [2:0]  octant;
    logic        angle_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    radian_phase_gen uut (
        .clk(clk), .rst_n(rst_n), .tune_load(tune_load), .tune_word(tune_word),
        .angle_rad(angle_rad), .octant(octant), .angle_valid(angle_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected angle for a phase value, from R5 and R6
    function automatic logic [17:0] exp_angle(input logic [31:0] ph);
        logic [21:0] f;
        longint unsigned p;
        f = ph[29] ? ~ph[28:7] : ph[28:7];
        p = longint'(f) * 64'd205887;
        return 18'(p >> 22);
    endfunction

    // reference model of the stated behaviour (R1..R4, R7)
    logic [31:0] m_word = '0, m_phase = '0;
    logic [17:0] e1_rad = '0, e2_rad = '0;
    logic [2:0]  e1_oct = '0, e2_oct = '0;
    logic        e1_v = 1'b0, e2_v = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word <= '0; m_phase <= '0;
            e1_rad <= '0; e2_rad <= '0; e1_oct <= '0; e2_oct <= '0;
            e1_v <= 1'b0; e2_v <= 1'b0;
        end else begin
            if (tune_load) m_word <= tune_word;
            m_phase <= m_phase + m_word;
            e1_rad <= exp_angle(m_phase); e1_oct <= m_phase[31:29]; e1_v <= 1'b1;
            e2_rad <= e1_rad; e2_oct <= e1_oct; e2_v <= e1_v;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one clock: drive on falling edge, compare all outputs at next falling edge
    task automatic cyc(input logic ld, input logic [31:0] w, input string req);
        tune_load = ld;
        tune_word = w;
        @(posedge clk);
        @(negedge clk);
        check(req, "valid", angle_valid, e2_v);
        check(req, "octant", octant, e2_oct);
        check(req, "angle", angle_rad, e2_rad);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, 32'hDEAD_BEEF, "R1");
        check("R1", "reset valid", angle_valid, 0);
        check("R1", "reset angle", angle_rad, 0);
        rst_n = 1'b1;
        // R1: valid rises after the second edge out of reset; word cleared so phase holds at 0
        cyc(1'b0, '0, "R1");
        check("R1", "valid after 1 edge", angle_valid, 0);
        cyc(1'b0, '0, "R1");
        check("R1", "valid after 2 edges", angle_valid, 1);
        check("R1", "angle with cleared word", angle_rad, 0);
        // R2: zero word holds phase
        for (int i = 0; i < 4; i++) cyc(1'b0, '0, "R2");
        // R4/R5: one octant per step; odd octants mirror to full scale
        cyc(1'b1, 32'h2000_0000, "R3");
        for (int i = 0; i < 10; i++) cyc(1'b0, '0, "R4");
        check("R5", "odd octant mirrored angle", angle_rad, (octant[0] ? 205886 : 0));
        // R3: load timing with a sub-octant word
        cyc(1'b1, 32'h0123_4567, "R3");
        for (int i = 0; i < 6; i++) cyc(1'b0, 32'hFFFF_FFFF, "R3");
        // R2: all-ones word steps the phase down through the wrap
        cyc(1'b1, 32'hFFFF_FFFF, "R2");
        for (int i = 0; i < 8; i++) cyc(1'b0, '0, "R2");
        // R7: back-to-back loads keep the phase running
        for (int i = 0; i < 8; i++) cyc(1'b1, $urandom, "R7");
        // R6: random words and load timing
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 16) == 0, $urandom, "R6");
        // R1: mid-run reset clears outputs and word
        rst_n = 1'b0;
        cyc(1'b0, '0, "R1");
        check("R1", "mid-run reset valid", angle_valid, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) cyc(1'b0, '0, "R1");
        check("R1", "word cleared by reset", angle_rad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule